// File: doc/BRIEF.md
# HDLC Transmit Packet Encapsulator

This block turns a stream of packet bytes into HDLC-style frames ready for a line. Each packet arrives as bytes marked with a start and an end. The block wraps the packet between two 0x7E flags. When asked, it computes a 16-bit or 32-bit frame check sequence (FCS) and appends it. It then makes the flag pattern unique inside the frame. In bit-synchronous mode it does this by zero-bit insertion. In octet-aligned mode it does this by escape-octet stuffing.

While no frame is being sent, the line carries a fill octet chosen by configuration. The source may deliver packets with or without their own FCS bytes. A supplied FCS is either forwarded untouched or removed and replaced by a freshly computed one. For test purposes, the FCS of the next frame, or of one frame in every N, can be deliberately corrupted.

The line produces one unit per clock: a bit on `line_bit` in bit mode, or an octet on `line_octet` in octet mode. The packet source is paced by `in_ready`. Configuration is expected to stay static while the block is out of reset.

Top module: `hdlc_tx_encap`

## Requirements
- R1: While reset is held, `line_bit`, `line_octet` and `in_ready` are 0. Outside frames, the line repeats the fill octet `cfg_fill` unstuffed (LSB first in bit mode), starting with the first clock after reset.
- R2: Every packet is sent as: flag 0x7E, payload bytes in arrival order, FCS bytes (when one is sent), then flag 0x7E.
- R3: With `cfg_fcs32`=0, the FCS is a 16-bit CRC computed LSB-first over the payload. It uses reflected polynomial 0x8408 and initial value 0xFFFF, is sent ones-complemented, and goes out low byte first.
- R4: With `cfg_fcs32`=1, the FCS is a 32-bit CRC with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF. It is sent ones-complemented, low byte first.
- R5: With `cfg_fcs_in`=0, every received byte is payload and the computed FCS is appended.
- R6: With `cfg_fcs_in`=1 and `cfg_fcs_ovr`=0, all received bytes (including the supplied FCS) are sent as payload and no FCS is added.
- R7: With `cfg_fcs_in`=1 and `cfg_fcs_ovr`=1, the last 2 (16-bit) or 4 (32-bit) received bytes are dropped. A freshly computed FCS over the remaining bytes takes their place.
- R8: In bit mode (`cfg_octet_mode`=0), octets leave LSB first. After five consecutive 1s of payload or FCS, a 0 is inserted. Flags and fill are never stuffed and restart the count.
- R9: In octet mode, a payload or FCS octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20. Flags and fill are sent as they are.
- R10: A pulse on `err_once` inverts bit 0 of the first FCS byte of the next frame whose FCS the block generates, and of that frame only.
- R11: With `err_rate`=N>0, every Nth frame with a generated FCS since reset gets bit 0 of its first FCS byte inverted.
- R12: A byte presented outside a packet without `in_sop` is accepted and discarded, with no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet byte present |
| in_data | input | 8 | Packet byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_ready | output | 1 | Byte taken this cycle |
| cfg_octet_mode | input | 1 | 1 = octet stuffing, 0 = bit stuffing |
| cfg_fcs32 | input | 1 | 1 = 32-bit FCS, 0 = 16-bit FCS |
| cfg_fcs_in | input | 1 | Packets already carry FCS bytes |
| cfg_fcs_ovr | input | 1 | Replace a supplied FCS |
| cfg_fill | input | 8 | Inter-frame fill octet |
| err_once | input | 1 | Corrupt the next generated FCS |
| err_rate | input | 16 | Corrupt one generated FCS in N (0 = off) |
| line_bit | output | 1 | Serial line bit (bit mode) |
| line_octet | output | 8 | Line octet (octet mode) |

## Verification
The line outputs are registered, so the unit the stuffer chooses in one cycle appears one clock later. The first fill unit is therefore visible after the first edge following reset release. The bench captures one unit 1 ns after every rising edge from that edge on. The offset of each frame depends on handshake pacing and stuffing, so the bench does not predict an absolute cycle for it. Instead it searches the capture for the exact expected unit sequence, in order, and checks that every unit before the first frame is fill. `in_ready` is combinational, so it is read 1 ns after the falling edge, before the edge that completes the transfer.

// File: rtl/hdlc_tx_pkg.sv
// Shared types, constants and the CRC step for the HDLC transmit encapsulator.
// Assumes CRCs are processed LSB first (reflected form).
package hdlc_tx_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_FCS, ST_CLOSE} frm_state_t;

    localparam logic [7:0] FLAG_OCT = 8'h7E;
    localparam logic [7:0] ESC_OCT  = 8'h7D;
    localparam logic [7:0] ESC_XOR  = 8'h20;

    // Preset value of the running CRC for the selected width.
    function automatic logic [31:0] fcs_init(input logic w32);
        return w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    // Advance the running CRC by one octet, LSB first.
    function automatic logic [31:0] fcs_step(input logic [31:0] c, input logic [7:0] d,
                                             input logic w32);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = {1'b0, r[31:1]};
            if (fb) r = r ^ (w32 ? 32'hEDB8_8320 : 32'h0000_8408);
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_err_sched.sv
// Decides whether the FCS of the frame now starting is corrupted.
// Assumes frame_go pulses once per frame whose FCS the block generates.
module hdlc_tx_err_sched #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_once,
    input  logic [RATE_W-1:0] err_rate,
    input  logic              frame_go,
    output logic              corrupt
);
    logic              pend;
    logic [RATE_W-1:0] cnt;
    logic              rate_hit;

    // Current frame is corrupted by a pending one-shot or the rate counter.
    always_comb begin
        rate_hit = (err_rate != '0) && (cnt == err_rate - RATE_W'(1));
        corrupt  = pend || rate_hit;
    end

    // Track the one-shot request and count generated frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else begin
            if (frame_go)      pend <= err_once;
            else if (err_once) pend <= 1'b1;
            if (frame_go)      cnt  <= rate_hit || (err_rate == '0) ? '0 : cnt + RATE_W'(1);
        end
    end

    // R10
    once_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && !err_once) |=> !pend);

    // R11
    rate_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && rate_hit && $stable(err_rate)) |=> (cnt == '0));

endmodule

// File: rtl/hdlc_tx_framer.sv
// Builds the unstuffed octet sequence: fill, opening flag, payload, FCS, closing flag.
// Holds back a supplied FCS when it is to be replaced. Each octet is tagged raw
// (flag or fill, never stuffed) or not. Assumes a packet, once started, is
// presented without gaps; a gap sends fill and stalls the frame.
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int HMAX = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sop,
    input  logic       in_eop,
    output logic       in_ready,
    input  logic       cfg_fcs32,
    input  logic       cfg_fcs_in,
    input  logic       cfg_fcs_ovr,
    input  logic [7:0] cfg_fill,
    input  logic       take,
    input  logic       corrupt,
    output logic       frame_go,
    output logic [7:0] oct,
    output logic       oct_raw
);
    localparam int HIW = $clog2(HMAX);
    localparam int HCW = $clog2(HMAX + 1);

    frm_state_t     state;
    logic [7:0]     hold [HMAX];
    logic [HCW-1:0] hcnt;
    logic           ended;
    logic [31:0]    crc;
    logic [1:0]     fidx;
    logic           bad;

    logic           gen, start_ok, stray, prime;
    logic [HCW-1:0] flen, hn;
    logic [31:0]    fcs_word;

    // Mode decode and the input-side acceptance conditions.
    always_comb begin
        gen      = !cfg_fcs_in || cfg_fcs_ovr;
        flen     = cfg_fcs32 ? HCW'(4) : HCW'(2);
        hn       = (cfg_fcs_in && cfg_fcs_ovr) ? flen : '0;
        start_ok = (state == ST_IDLE) &&
                   ((hn == '0) ? (in_valid && in_sop) : (hcnt == hn || ended));
        stray    = (state == ST_IDLE) && (hcnt == '0) && !ended && in_valid && !in_sop;
        prime    = (state == ST_IDLE) && (hn != '0) && !ended && (hcnt < hn) &&
                   in_valid && (hcnt != '0 || in_sop);
        in_ready = stray || prime || ((state == ST_DATA) && take);
        frame_go = take && start_ok && gen;
        fcs_word = ~crc;
    end

    // Select the octet offered to the stuffer in the current state.
    always_comb begin
        oct     = cfg_fill;
        oct_raw = 1'b1;
        case (state)
            ST_IDLE:  oct = start_ok ? FLAG_OCT : cfg_fill;
            ST_DATA:  if (in_valid) begin
                          oct     = (hn == '0) ? in_data : hold[0];
                          oct_raw = 1'b0;
                      end
            ST_FCS:   begin
                          oct     = fcs_word[{fidx, 3'b000} +: 8] ^ {7'd0, bad && fidx == 2'd0};
                          oct_raw = 1'b0;
                      end
            default:  oct = FLAG_OCT;
        endcase
    end

    // Frame sequencing, supplied-FCS holdback and CRC accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hcnt  <= '0;
            ended <= 1'b0;
            crc   <= '0;
            fidx  <= '0;
            bad   <= 1'b0;
            for (int i = 0; i < HMAX; i++) hold[i] <= '0;
        end else begin
            if (prime) begin
                hold[hcnt[HIW-1:0]] <= in_data;
                hcnt                <= hcnt + HCW'(1);
                if (in_eop) ended <= 1'b1;
            end
            if (take) begin
                case (state)
                    ST_IDLE: if (start_ok) begin
                        crc   <= fcs_init(cfg_fcs32);
                        bad   <= corrupt && gen;
                        fidx  <= '0;
                        state <= ended ? ST_FCS : ST_DATA;
                    end
                    ST_DATA: if (in_valid) begin
                        crc <= fcs_step(crc, oct, cfg_fcs32);
                        if (hn != '0) begin
                            for (int i = 0; i < HMAX - 1; i++) hold[i] <= hold[i+1];
                            hold[HIW'(hn - HCW'(1))] <= in_data;
                        end
                        if (in_eop) state <= gen ? ST_FCS : ST_CLOSE;
                    end
                    ST_FCS: begin
                        fidx <= fidx + 2'd1;
                        if (HCW'(fidx) == flen - HCW'(1)) state <= ST_CLOSE;
                    end
                    default: begin
                        state <= ST_IDLE;
                        hcnt  <= '0;
                        ended <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R12
    stray_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stray |=> (state == ST_IDLE && hcnt == '0 && !ended));

    // R5
    fcs_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && take && in_valid && in_eop && gen) |=> (state == ST_FCS));

    // R6
    pass_no_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fcs_in && !cfg_fcs_ovr) |-> (state != ST_FCS));

    // R2
    close_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSE && take) |=> (state == ST_IDLE && hcnt == '0));

endmodule

// File: rtl/hdlc_tx_stuffer.sv
// Serialises tagged octets onto the line with bit or octet stuffing, one line
// unit per clock, and pulls the next octet from the framer through take.
// Assumes the mode does not change while out of reset.
module hdlc_tx_stuffer
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_octet_mode,
    input  logic [7:0] cfg_fill,
    input  logic [7:0] nxt_oct,
    input  logic       nxt_raw,
    output logic       take,
    output logic       line_bit,
    output logic [7:0] line_octet
);
    logic [7:0] cur;
    logic       cur_raw;
    logic [2:0] idx;
    logic [2:0] ones;
    logic       esc_pend;
    logic       special, stuff_now, bit_val;
    logic [7:0] oct_val;

    // Choose this cycle's line unit and whether the current octet is finished.
    always_comb begin
        special   = !cur_raw && (cur == FLAG_OCT || cur == ESC_OCT);
        stuff_now = !cfg_octet_mode && (ones == 3'd5);
        bit_val   = 1'b0;
        oct_val   = 8'h00;
        take      = 1'b0;
        if (cfg_octet_mode) begin
            if (esc_pend) begin
                oct_val = cur ^ ESC_XOR;
                take    = 1'b1;
            end else if (special) begin
                oct_val = ESC_OCT;
            end else begin
                oct_val = cur;
                take    = 1'b1;
            end
        end else if (!stuff_now) begin
            bit_val = cur[idx];
            take    = (idx == 3'd7);
        end
    end

    // Register the line unit and advance bit position, ones run and escape state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur        <= cfg_fill;
            cur_raw    <= 1'b1;
            idx        <= '0;
            ones       <= '0;
            esc_pend   <= 1'b0;
            line_bit   <= 1'b0;
            line_octet <= '0;
        end else begin
            line_bit   <= bit_val;
            line_octet <= oct_val;
            esc_pend   <= cfg_octet_mode && !esc_pend && special;
            if (!cfg_octet_mode) begin
                if (stuff_now) begin
                    ones <= '0;
                end else begin
                    idx  <= idx + 3'd1;
                    ones <= (cur_raw || !bit_val) ? 3'd0 : ones + 3'd1;
                end
            end
            if (take) begin
                cur     <= nxt_oct;
                cur_raw <= nxt_raw;
            end
        end
    end

    // R8
    zero_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_now |=> !line_bit);

    // R9
    escape_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_pend |-> (line_octet == ESC_OCT));

endmodule

// File: rtl/hdlc_tx_encap.sv
// Top of the HDLC transmit encapsulator: framer feeds the stuffer, and the
// error scheduler marks frames whose generated FCS is to be corrupted.
// Assumes configuration inputs are static while out of reset.
module hdlc_tx_encap #(
    parameter int RATE_W = 16,
    parameter int HMAX   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              in_ready,
    input  logic              cfg_octet_mode,
    input  logic              cfg_fcs32,
    input  logic              cfg_fcs_in,
    input  logic              cfg_fcs_ovr,
    input  logic [7:0]        cfg_fill,
    input  logic              err_once,
    input  logic [RATE_W-1:0] err_rate,
    output logic              line_bit,
    output logic [7:0]        line_octet
);
    logic       take, corrupt, frame_go, oct_raw;
    logic [7:0] oct;

    hdlc_tx_err_sched #(.RATE_W(RATE_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .err_once(err_once), .err_rate(err_rate),
        .frame_go(frame_go), .corrupt(corrupt)
    );

    hdlc_tx_framer #(.HMAX(HMAX)) u_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
        .cfg_fcs32(cfg_fcs32), .cfg_fcs_in(cfg_fcs_in), .cfg_fcs_ovr(cfg_fcs_ovr),
        .cfg_fill(cfg_fill), .take(take), .corrupt(corrupt), .frame_go(frame_go),
        .oct(oct), .oct_raw(oct_raw)
    );

    hdlc_tx_stuffer u_stuffer (
        .clk(clk), .rst_n(rst_n), .cfg_octet_mode(cfg_octet_mode), .cfg_fill(cfg_fill),
        .nxt_oct(oct), .nxt_raw(oct_raw), .take(take),
        .line_bit(line_bit), .line_octet(line_octet)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!line_bit && line_octet == 8'h00));

endmodule

// File: tb/hdlc_tx_encap_tb.sv
`timescale 1ns/1ps
module hdlc_tx_encap_tb;
    localparam int CAPN = 1500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        cfg_octet_mode = 1'b0, cfg_fcs32 = 1'b0, cfg_fcs_in = 1'b0, cfg_fcs_ovr = 1'b0;
    logic [7:0]  cfg_fill = 8'h7E;
    logic        err_once = 1'b0;
    logic [15:0] err_rate = '0;
    logic        line_bit;
    logic [7:0]  line_octet;

    int total = 0, bad = 0;

    logic [7:0] cap [CAPN];
    int         cap_n = 0;
    logic       cap_en = 1'b0;

    logic [7:0] pkt [4][32];
    int         plen [4];
    logic [7:0] eo [80];
    bit         er [80];
    logic [7:0] eu [1200];
    int         exp_n;

    always #2.5 clk = ~clk;

    hdlc_tx_encap u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
        .cfg_octet_mode(cfg_octet_mode), .cfg_fcs32(cfg_fcs32), .cfg_fcs_in(cfg_fcs_in),
        .cfg_fcs_ovr(cfg_fcs_ovr), .cfg_fill(cfg_fill), .err_once(err_once),
        .err_rate(err_rate), .line_bit(line_bit), .line_octet(line_octet)
    );

    // Capture one line unit per clock, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (cap_en && cap_n < CAPN) begin
            cap[cap_n] = cfg_octet_mode ? line_octet : {7'd0, line_bit};
            cap_n++;
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL R2 watchdog: actual=still running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [7:0] d, input bit w32);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] != d[b]) r = (r >> 1) ^ (w32 ? 32'hEDB88320 : 32'h00008408);
            else              r = r >> 1;
        end
        return r;
    endfunction

    function automatic void push_u(input logic [7:0] u);
        eu[exp_n] = u;
        exp_n++;
    endfunction

    // Expected line units of frame k, from the requirements.
    function automatic void build_exp(input int k, input bit corr);
        int n = 0, dl, fl, ones;
        logic [31:0] c;
        fl = cfg_fcs32 ? 4 : 2;
        dl = (cfg_fcs_in && cfg_fcs_ovr) ? plen[k] - fl : plen[k];
        c  = cfg_fcs32 ? 32'hFFFFFFFF : 32'h0000FFFF;
        eo[n] = 8'h7E; er[n] = 1; n++;
        for (int i = 0; i < dl; i++) begin
            eo[n] = pkt[k][i]; er[n] = 0; n++;
            c = crc_bits(c, pkt[k][i], cfg_fcs32);
        end
        if (!cfg_fcs_in || cfg_fcs_ovr) begin
            c = ~c;
            if (corr) c[0] = ~c[0];
            for (int i = 0; i < fl; i++) begin eo[n] = c[8*i +: 8]; er[n] = 0; n++; end
        end
        eo[n] = 8'h7E; er[n] = 1; n++;
        exp_n = 0;
        ones  = 0;
        for (int i = 0; i < n; i++) begin
            if (cfg_octet_mode) begin
                if (!er[i] && (eo[i] == 8'h7E || eo[i] == 8'h7D)) begin
                    push_u(8'h7D); push_u(eo[i] ^ 8'h20);
                end else push_u(eo[i]);
            end else begin
                for (int b = 0; b < 8; b++) begin
                    push_u({7'd0, eo[i][b]});
                    if (er[i]) ones = 0;
                    else begin
                        ones = eo[i][b] ? ones + 1 : 0;
                        if (ones == 5) begin push_u(8'h00); ones = 0; end
                    end
                end
            end
        end
    endfunction

    function automatic int find_exp(input int from);
        for (int p = from; p + exp_n <= cap_n; p++) begin
            bit ok = 1;
            for (int j = 0; j < exp_n && ok; j++) if (cap[p+j] !== eu[j]) ok = 0;
            if (ok) return p;
        end
        return -1;
    endfunction

    task automatic send_byte(input logic [7:0] d, input bit s, input bit e);
        logic acc;
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        do begin
            #1; acc = in_ready;
            @(negedge clk);
        end while (!acc);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic run_case(input bit om, input bit f32, input bit fin, input bit fovr,
                            input logic [7:0] fill, input int rate, input bit once);
        string tags;
        int fl, pos, first, g, p;
        bit gen, corr, ok;
        @(negedge clk);
        rst_n = 1'b0; cap_en = 1'b0;
        cfg_octet_mode = om; cfg_fcs32 = f32; cfg_fcs_in = fin; cfg_fcs_ovr = fovr;
        cfg_fill = fill; err_rate = 16'(rate);
        repeat (3) @(negedge clk);
        total++;
        if (line_octet !== 8'h00 || line_bit !== 1'b0 || in_ready !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: actual oct=%h bit=%b rdy=%b expected 00 0 0",
                     line_octet, line_bit, in_ready);
        end
        fl = f32 ? 4 : 2;
        plen[0] = 8; plen[1] = 9; plen[2] = 13; plen[3] = fin ? fl + 1 : 1;
        for (int i = 0; i < 32; i++) begin
            pkt[0][i] = (i % 3 == 0) ? 8'h7E : (i % 3 == 1) ? 8'h7D : 8'(i * 37 + 1);
            pkt[1][i] = 8'hFF;
            pkt[2][i] = 8'((i * 113 + 29) ^ (i << 3));
            pkt[3][i] = 8'hF8 ^ 8'(i);
        end
        tags = {om ? "R9" : "R8", f32 ? " R4" : " R3",
                !fin ? " R5" : (fovr ? " R7" : " R6")};
        cap_n = 0; cap_en = 1'b1; rst_n = 1'b1;
        if (once) begin err_once = 1'b1; @(negedge clk); err_once = 1'b0; end
        send_byte(8'h55, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < plen[k]; i++) send_byte(pkt[k][i], i == 0, i == plen[k] - 1);
        wait (cap_n == CAPN);
        cap_en = 1'b0;
        gen = !fin || fovr;
        pos = 0; first = -1; g = 0;
        for (int k = 0; k < 4; k++) begin
            corr = gen && ((once && g == 0) || (rate != 0 && (g + 1) % rate == 0));
            if (gen) g++;
            build_exp(k, corr);
            p = find_exp(pos);
            total++;
            if (p < 0) begin
                bad++;
                $display("FAIL R2 %s%s frame %0d: actual=not found expected=%0d-unit frame (corrupt=%0b)",
                         tags, corr ? (once ? " R10" : " R11") : "", k, exp_n, corr);
            end else begin
                pos = p + exp_n;
                if (k == 0) first = p;
            end
        end
        // R1 / R12: line carries only fill before the first frame; stray byte leaves no trace.
        total++;
        ok = (first >= 0);
        for (int i = 0; ok && i < first; i++)
            if (cap[i] !== (om ? fill : {7'd0, fill[i % 8]})) begin
                ok = 0;
                $display("FAIL R1 R12 idle fill at unit %0d: actual=%h expected=%h",
                         i, cap[i], om ? fill : {7'd0, fill[i % 8]});
            end
        if (!ok) begin
            bad++;
            if (first < 0) $display("FAIL R1 R12 idle fill: actual=no first frame expected=frame after fill");
        end
    endtask

    initial begin
        for (int om = 0; om < 2; om++)
            for (int f32 = 0; f32 < 2; f32++)
                for (int fc = 0; fc < 3; fc++)
                    run_case(om[0], f32[0], fc != 0, fc == 2,
                             om ? 8'hA5 : (f32 ? 8'hFF : 8'h7E), 0, 1'b0);
        run_case(1'b0, 1'b0, 1'b0, 1'b0, 8'h7E, 2, 1'b0);   // R11 every 2nd frame
        run_case(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 3, 1'b0);   // R11 every 3rd frame
        run_case(1'b1, 1'b0, 1'b0, 1'b0, 8'h7E, 0, 1'b1);   // R10 one-shot
        run_case(1'b0, 1'b1, 1'b1, 1'b0, 8'h7E, 0, 1'b1);   // R10 no generated FCS, no effect
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule